// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 operands of half, single or double precision and produces two views of the same relation. The first is a four-bit condition nibble laid out as N, Z, C, V (bit 3 down to bit 0), as a scalar compare would write it. The second is a lane mask that is all ones across the element width when a chosen vector test (equal, greater-or-equal, greater) holds and zero otherwise. An invalid-operation flag accompanies every result.

Two mode pins shape each compare. A signalling select makes any NaN raise invalid, where a quiet compare raises it only for signalling NaNs. A magnitude select discards both sign bits before the compare. Operands sit in the low bits of 64-bit buses; bits above the selected format are ignored. Subnormals are ordered as ordinary values and zeros of either sign compare equal.

Requests enter through a valid/ready stream and results leave through another. A request is taken on a clock edge where `in_valid` and `in_ready` are both high, and its result is presented one cycle later. `in_ready` is high whenever the output register is empty or is being drained in the same cycle; while `out_valid` is high and `out_ready` low, the result is held unchanged and no new request is taken.

Top module: `fpcmp_flags`

## Requirements
- R1: Equal operands give the nibble 4'b0110 (Z and C set, N and V clear).
- R2: If a is less than b the nibble is 4'b1000; if a is greater than b the nibble is 4'b0010.
- R3: If either operand is a NaN (exponent all ones, fraction non-zero) the relation is unordered and the nibble is 4'b0011.
- R4: Positive and negative zero compare equal; subnormals are ordered by value like any other finite number.
- R5: With `sig_mode` low, `invalid` is high only when an operand is a signalling NaN (fraction top bit clear); a quiet NaN gives unordered flags with `invalid` low.
- R6: With `sig_mode` high, `invalid` is high when either operand is any NaN.
- R7: With `abs_mode` high both sign bits are ignored, so the compare is by magnitude; a NaN stays unordered.
- R8: `test_sel` picks the mask test: 0 equal, 1 greater-or-equal, 2 greater, 3 never true. A true test sets every bit of the element (16, 32 or 64 low bits) and leaves the bits above it zero; a false test gives zero.
- R9: An unordered relation makes every mask test false.
- R10: `fmt` 0 selects half, 1 single, 2 double and 3 also double; operand bits above the selected width have no effect.
- R11: A result is presented one cycle after its request is taken; while `out_valid` is high and `out_ready` low, the outputs hold and `in_ready` is low.
- R12: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| fmt | input | 2 | Operand format: 0 half, 1 single, 2/3 double |
| sig_mode | input | 1 | 1 = signalling compare, 0 = quiet |
| abs_mode | input | 1 | 1 = compare magnitudes |
| test_sel | input | 2 | Mask test: 0 eq, 1 ge, 2 gt, 3 never |
| op_a | input | 64 | First operand, right aligned |
| op_b | input | 64 | Second operand, right aligned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be consumed |
| out_flags | output | 4 | N, Z, C, V nibble (bit 3 to bit 0) |
| out_mask | output | 64 | Lane mask, element width from fmt |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The only state is the one-entry result register, so a wrong capture or a lost hold shows at the ports on the very next cycle: a stalled result that changes, a flag nibble outside the four legal codes, or a mask that disagrees with the nibble. A wrong classification of NaN kind, zero sign or element width appears as a wrong nibble, mask or invalid bit in the cycle after the request is taken. The vectors therefore pair every relation, both NaN kinds and both zero signs with each format, and the stall test checks the held values cycle by cycle.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int DATA_W  = 64;
  localparam int MAG_W   = DATA_W - 1;
  localparam int NUM_FMT = 3;

  // exponent and fraction widths, indexed by format code
  localparam int EXP_W_TBL [NUM_FMT] = '{5, 8, 11};
  localparam int MAN_W_TBL [NUM_FMT] = '{10, 23, 52};

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_ALT_D  = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef enum logic [1:0] {
    TST_EQ    = 2'd0,
    TST_GE    = 2'd1,
    TST_GT    = 2'd2,
    TST_NEVER = 2'd3
  } tst_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;

endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int TOT_W = EXP_W + MAN_W + 1
) (
  input  logic [TOT_W-1:0] raw,
  input  logic             abs_en,
  output opnd_t            fields
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = raw[MAN_W +: EXP_W];
  assign man_f = raw[MAN_W-1:0];

  always_comb begin
    fields      = '0;
    fields.sign = raw[TOT_W-1] & ~abs_en;
    fields.nan  = (&exp_f) & (|man_f);
    fields.snan = (&exp_f) & (|man_f) & ~man_f[MAN_W-1];
    fields.zero = ~(|exp_f) & ~(|man_f);
    fields.mag  = MAG_W'({exp_f, man_f});
  end
endmodule

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
(
  input  logic [DATA_W-1:0] raw,
  input  fmt_e              fmt,
  input  logic              abs_en,
  output opnd_t             fields
);
  opnd_t per_fmt [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = EXP_W_TBL[g];
    localparam int MW = MAN_W_TBL[g];
    fpcmp_unpack #(.EXP_W(EW), .MAN_W(MW)) u_unpack (
      .raw    (raw[EW+MW:0]),
      .abs_en (abs_en),
      .fields (per_fmt[g])
    );
  end

  always_comb begin
    unique case (fmt)
      FMT_HALF:   fields = per_fmt[0];
      FMT_SINGLE: fields = per_fmt[1];
      default:    fields = per_fmt[2];
    endcase
  end
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
  import fpcmp_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  input  logic  sig_mode,
  output rel_e  rel,
  output logic  invalid
);
  logic mag_lt, mag_eq;

  assign mag_lt = a.mag < b.mag;
  assign mag_eq = a.mag == b.mag;

  always_comb begin
    if (a.nan || b.nan)          rel = REL_UN;
    else if (a.zero && b.zero)   rel = REL_EQ;
    else if (a.sign != b.sign)   rel = a.sign ? REL_LT : REL_GT;
    else if (mag_eq)             rel = REL_EQ;
    else if (a.sign)             rel = mag_lt ? REL_GT : REL_LT;
    else                         rel = mag_lt ? REL_LT : REL_GT;
  end

  assign invalid = sig_mode ? (a.nan | b.nan) : (a.snan | b.snan);
endmodule

// File: rtl/fpcmp_encode.sv
module fpcmp_encode
  import fpcmp_pkg::*;
(
  input  rel_e              rel,
  input  tst_e              tst,
  input  fmt_e              fmt,
  output logic [3:0]        flags,
  output logic [DATA_W-1:0] mask
);
  logic             hit;
  logic [DATA_W-1:0] lane_ones;

  always_comb begin
    unique case (rel)
      REL_EQ:  flags = 4'b0110;
      REL_LT:  flags = 4'b1000;
      REL_GT:  flags = 4'b0010;
      default: flags = 4'b0011;
    endcase
  end

  always_comb begin
    unique case (tst)
      TST_EQ:  hit = (rel == REL_EQ);
      TST_GE:  hit = (rel == REL_EQ) || (rel == REL_GT);
      TST_GT:  hit = (rel == REL_GT);
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    lane_ones = '0;
    unique case (fmt)
      FMT_HALF:   lane_ones[(1 + EXP_W_TBL[0] + MAN_W_TBL[0])-1:0] = '1;
      FMT_SINGLE: lane_ones[(1 + EXP_W_TBL[1] + MAN_W_TBL[1])-1:0] = '1;
      default:    lane_ones = '1;
    endcase
  end

  assign mask = hit ? lane_ones : '0;
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        fmt,
  input  logic              sig_mode,
  input  logic              abs_mode,
  input  logic [1:0]        test_sel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_flags,
  output logic [DATA_W-1:0] out_mask,
  output logic              out_invalid
);
  fmt_e              fmt_q;
  tst_e              tst_q;
  opnd_t             fa, fb;
  rel_e              rel;
  logic              inv_c;
  logic [3:0]        flags_c;
  logic [DATA_W-1:0] mask_c;
  logic              take;

  assign fmt_q = fmt_e'(fmt);
  assign tst_q = tst_e'(test_sel);

  fpcmp_classify u_cls_a (.raw(op_a), .fmt(fmt_q), .abs_en(abs_mode), .fields(fa));
  fpcmp_classify u_cls_b (.raw(op_b), .fmt(fmt_q), .abs_en(abs_mode), .fields(fb));

  fpcmp_relate u_rel (
    .a(fa), .b(fb), .sig_mode(sig_mode), .rel(rel), .invalid(inv_c)
  );

  fpcmp_encode u_enc (
    .rel(rel), .tst(tst_q), .fmt(fmt_q), .flags(flags_c), .mask(mask_c)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_flags   <= '0;
      out_mask    <= '0;
      out_invalid <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_flags   <= flags_c;
      out_mask    <= mask_c;
      out_invalid <= inv_c;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/fpcmp_flags_chk.sv
module fpcmp_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [3:0]  out_flags,
  input logic [63:0] out_mask,
  input logic        out_invalid
);
  // R1 R2 R3: only the four legal nibbles appear
  assert_legal_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags == 4'b0110 || out_flags == 4'b1000 ||
                   out_flags == 4'b0010 || out_flags == 4'b0011));

  assert_unordered_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags == 4'b0011) |-> out_mask == '0);

  assert_invalid_only_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> out_flags == 4'b0011);

  assert_mask_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask) == 0 || $countones(out_mask) == 16 ||
                   $countones(out_mask) == 32 || $countones(out_mask) == 64));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flags) &&
                                   $stable(out_mask) && $stable(out_invalid)));

  assert_stall_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready));
endmodule

bind fpcmp_flags fpcmp_flags_chk chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_flags(out_flags), .out_mask(out_mask),
  .out_invalid(out_invalid)
);

// File: tb/tb_fpcmp_flags.sv
module tb_fpcmp_flags;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 30;
  localparam int VW = 140;

  // entry: fmt, sig, abs, sel, a, b, flags, invalid, mask_true
  function automatic logic [VW-1:0] mk(logic [1:0] f, logic s, logic ab,
      logic [1:0] t, logic [63:0] a, logic [63:0] b, logic [3:0] fl,
      logic inv, logic mt);
    return {f, s, ab, t, a, b, fl, inv, mt};
  endfunction

  localparam logic [VW-1:0] VEC [NVEC] = '{
    mk(0,0,0,0, 64'h3C00, 64'h3C00, 4'h6,0,1),                       // 0 R1
    mk(0,0,0,1, 64'h3C00, 64'h4000, 4'h8,0,0),                       // 1 R2
    mk(0,0,0,2, 64'h4000, 64'h3C00, 4'h2,0,1),                       // 2 R2
    mk(0,0,0,0, 64'h0000, 64'h8000, 4'h6,0,1),                       // 3 R4
    mk(0,0,0,1, 64'h7E00, 64'h3C00, 4'h3,0,0),                       // 4 R3 R5
    mk(0,0,0,0, 64'h7C01, 64'h3C00, 4'h3,1,0),                       // 5 R5
    mk(0,1,0,1, 64'h7E00, 64'h3C00, 4'h3,1,0),                       // 6 R6
    mk(0,0,1,2, 64'hC000, 64'h3C00, 4'h2,0,1),                       // 7 R7
    mk(0,0,0,2, 64'hC000, 64'h3C00, 4'h8,0,0),                       // 8 R2
    mk(0,0,0,1, 64'hFFFFFFFFFFFF3C00, 64'h0000123400004000, 4'h8,0,0), // 9 R10
    mk(0,0,0,1, 64'hBC00, 64'hC000, 4'h2,0,1),                       // 10 R2 neg
    mk(0,0,0,2, 64'h7C00, 64'h7BFF, 4'h2,0,1),                       // 11 inf
    mk(0,0,0,2, 64'h0001, 64'h0000, 4'h2,0,1),                       // 12 R4 subn
    mk(1,0,0,0, 64'h3F800000, 64'h3F800000, 4'h6,0,1),               // 13
    mk(1,0,0,2, 64'h3F800000, 64'h40000000, 4'h8,0,0),               // 14
    mk(1,0,0,1, 64'hC0000000, 64'h3F800000, 4'h8,0,0),               // 15
    mk(1,1,0,0, 64'h7FC00000, 64'h3F800000, 4'h3,1,0),               // 16 R6
    mk(1,0,0,0, 64'h3F800000, 64'h7F800001, 4'h3,1,0),               // 17 R5
    mk(1,0,1,1, 64'hC0000000, 64'h40000000, 4'h6,0,1),               // 18 R7
    mk(1,0,0,0, 64'h80000000, 64'h00000000, 4'h6,0,1),               // 19 R4
    mk(2,0,0,1, 64'h4000000000000000, 64'h3FF0000000000000, 4'h2,0,1), // 20
    mk(2,0,0,0, 64'hBFF0000000000000, 64'hBFF0000000000000, 4'h6,0,1), // 21
    mk(2,0,0,2, 64'hBFF0000000000000, 64'h3FF0000000000000, 4'h8,0,0), // 22
    mk(2,1,0,2, 64'h7FF8000000000000, 64'h7FF8000000000000, 4'h3,1,0), // 23 R6
    mk(2,0,0,0, 64'h7FF8000000000000, 64'h7FF0000000000001, 4'h3,1,0), // 24 R5
    mk(2,0,0,1, 64'h7FF8000000000000, 64'h0, 4'h3,0,0),              // 25 R9
    mk(2,0,1,2, 64'h8000000000000000, 64'h0, 4'h6,0,0),              // 26 R7
    mk(2,0,0,3, 64'h3FF0000000000000, 64'h3FF0000000000000, 4'h6,0,0), // 27 R8
    mk(2,0,1,1, 64'hFFF8000000000000, 64'h0, 4'h3,0,0),              // 28 R7
    mk(3,0,0,2, 64'h4000000000000000, 64'h3FF0000000000000, 4'h2,0,1)  // 29 R10
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [1:0]  fmt = 0;
  logic        sig_mode = 0, abs_mode = 0;
  logic [1:0]  test_sel = 0;
  logic [63:0] op_a = 0, op_b = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [3:0]  out_flags;
  logic [63:0] out_mask;
  logic        out_invalid;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcmp_flags dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fmt(fmt), .sig_mode(sig_mode), .abs_mode(abs_mode), .test_sel(test_sel),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_flags(out_flags), .out_mask(out_mask), .out_invalid(out_invalid)
  );

  function automatic logic [63:0] lane(logic [1:0] f);
    case (f)
      2'd0:    return 64'h000000000000FFFF;
      2'd1:    return 64'h00000000FFFFFFFF;
      default: return '1;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [VW-1:0] e);
    {fmt, sig_mode, abs_mode, test_sel, op_a, op_b} = e[VW-1:6];
  endtask

  task automatic check_out(logic [VW-1:0] e, int idx);
    string tag;
    tag = $sformatf("R1-3 vec%0d flags", idx);
    chk(tag, 64'(out_flags), 64'(e[5:2]));
    chk($sformatf("R5/R6 vec%0d invalid", idx), 64'(out_invalid), 64'(e[1]));
    chk($sformatf("R8 vec%0d mask", idx), out_mask, e[0] ? lane(e[VW-1:VW-2]) : 64'h0);
  endtask

  initial begin
    // R12: reset state
    #(CLK_PERIOD*2 + 1);
    chk("R12 out_valid in reset", 64'(out_valid), 0);
    chk("R12 in_ready in reset", 64'(in_ready), 1);
    @(negedge clk); rst_n = 1;

    // table walk, R11: result one cycle after acceptance
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i]); in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      chk($sformatf("R11 vec%0d out_valid", i), 64'(out_valid), 1);
      check_out(VEC[i], i);
    end
    @(negedge clk);
    chk("R11 drained", 64'(out_valid), 0);

    // R11: back-pressure
    out_ready = 0;
    drive(VEC[2]); in_valid = 1;
    @(negedge clk);
    drive(VEC[5]);
    chk("R11 stall in_ready", 64'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 stall valid", 64'(out_valid), 1);
    check_out(VEC[2], 2);
    chk("R11 stall in_ready hold", 64'(in_ready), 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R11 second valid", 64'(out_valid), 1);
    check_out(VEC[5], 5);
    @(negedge clk);
    chk("R11 empty", 64'(out_valid), 0);

    // R12: reset mid-run clears the output
    drive(VEC[0]); in_valid = 1; out_ready = 0;
    @(negedge clk); in_valid = 0;
    rst_n = 0; #1;
    chk("R12 reset clears valid", 64'(out_valid), 0);
    @(negedge clk); rst_n = 1; out_ready = 1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule